// File: doc/BRIEF.md
# Zero-Initialised Word Memory on an APB Slave Port

This block is an APB completer that behaves as a small on-chip scratch memory. A requester writes 32-bit words into it and reads them back over a plain two-phase APB transfer. Every transfer takes exactly two cycles: one setup cycle and one access cycle. There is no wait-state or error response. The memory occupies a 4 KB window that starts at address zero and holds 1024 word locations.

The block tracks a valid flag for each word. A location that has not been written since the last reset reads back as zero, whatever its storage cell contains. Reset clears every flag in one step, so a reset empties the whole memory without clearing the data array word by word. Addresses outside the window and addresses that are not word-aligned are treated as holes. A write to a hole is dropped and a read from a hole returns zero. The read-data bus is zero at all times except during the access cycle of a read.

The reset input is active low. It asserts asynchronously and is released synchronously inside the block.

Top module: `apbm_mem_slave`

## Requirements
- R1: While `rst_n` is low, `bus_rdata` is zero. When `rst_n` falls, `bus_rdata` clears at once, without waiting for a clock edge.
- R2: A write is committed at the clock edge that ends its access cycle. A write is a cycle with `bus_sel`=1, `bus_enable`=0 and `bus_write`=1, followed by a cycle with `bus_sel`=1 and `bus_enable`=1. The word committed is the `bus_wdata` present in the access cycle.
- R3: For a read, `bus_rdata` carries the stored word throughout the access cycle. The stored word is loaded at the edge that ends the setup cycle. A read is a setup cycle with `bus_write`=0.
- R4: A read of an in-window location that has not been written since the last reset returns zero.
- R5: After a reset, every location reads zero until it is written again.
- R6: An address is a hole if any of bits 31:12 is nonzero or if bits 1:0 are not 00. A write to a hole changes no location, including the location whose low bits alias it. A read of a hole returns zero.
- R7: `bus_rdata` is zero in every cycle that is not the access cycle of a read. This includes the access cycle of a write and the cycle after a read completes.
- R8: A cycle with `bus_sel`=1 and `bus_enable`=1 that does not follow a setup cycle neither writes nor drives read data.
- R9: Transfers can run back to back with no idle cycle between them. A read that immediately follows a write to the same address returns the new word.
- R10: The last word of the window, at byte address 0xFFC, is stored and returned like every other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously inside the block |
| bus_sel | input | 1 | Completer select |
| bus_enable | input | 1 | Marks the access cycle of a transfer |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data, sampled in the access cycle |
| bus_rdata | output | 32 | Read data; zero outside a read access cycle |

## Verification
The bench builds the block with its default parameters: 32-bit address and data, a 12-bit window (1024 words) and a two-stage reset synchroniser. With these values the last word at 0xFFC can be reached, and an out-of-window write to 0x1000 aliases word 0. A design that failed to decode the upper address bits would therefore corrupt that word, and the bench would see it. The two-stage release also forces the bench to wait out the synchroniser before its first transfer, and to check that a mid-read reset clears the read-data bus without a clock edge.

// File: rtl/apbm_pkg.sv
package apbm_pkg;
  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_ACCESS = 1'b1
  } apbm_phase_e;
endpackage

// File: rtl/apbm_rst_sync.sv
module apbm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/apbm_phase.sv
module apbm_phase
  import apbm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 12,
  localparam int IDX_W   = WIN_BITS - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_enable,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_en,
  output logic              rd_en,
  output logic [IDX_W-1:0]  idx
);
  apbm_phase_e ph_q, ph_d;
  logic        in_window;
  logic        is_setup;

  assign in_window = (bus_addr[ADDR_W-1:WIN_BITS] == '0) && (bus_addr[1:0] == 2'b00);
  assign is_setup  = bus_sel && !bus_enable;
  assign idx       = bus_addr[WIN_BITS-1:2];

  always_comb begin
    ph_d = is_setup ? PH_ACCESS : PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else begin
      ph_q <= ph_d;
    end
  end

  // commit at the edge closing a genuine access cycle
  assign wr_en = (ph_q == PH_ACCESS) && bus_sel && bus_enable && bus_write && in_window;
  // look up at the edge closing the setup cycle of a read
  assign rd_en = is_setup && !bus_write && in_window;
endmodule

// File: rtl/apbm_store.sv
module apbm_store #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    vld_d = vld_q;
    if (wr_en) begin
      vld_d[idx] = 1'b1;
    end
  end

  always_comb begin
    rdata_d = (rd_en && vld_q[idx]) ? mem_q[idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      rdata_q <= '0;
    end else begin
      vld_q   <= vld_d;
      rdata_q <= rdata_d;
    end
  end

  // data array carries no reset; the valid bits mask stale contents
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[idx] <= wdata;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/apbm_mem_slave.sv
module apbm_mem_slave #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int WIN_BITS    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_enable,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int IDX_W = WIN_BITS - 2;

  logic             rst_int_n;
  logic             wr_en;
  logic             rd_en;
  logic [IDX_W-1:0] idx;

  apbm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_int_n)
  );

  apbm_phase #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_phase (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bus_sel    (bus_sel),
    .bus_enable (bus_enable),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .idx        (idx)
  );

  apbm_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .idx   (idx),
    .wdata (bus_wdata),
    .rdata (bus_rdata)
  );
endmodule

// File: rtl/apbm_mem_slave_chk.sv
module apbm_mem_slave_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WIN_BITS = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_enable,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata
);
  logic hole;
  assign hole = (bus_addr[ADDR_W-1:WIN_BITS] != '0) || (bus_addr[1:0] != 2'b00);

  // R1: read data is zero whenever reset is applied
  p_reset_rdata_r1: assert property (@(posedge clk)
    !rst_n |-> bus_rdata == '0);

  // R7: outside a read access cycle the read bus is zero
  p_rdata_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_enable && !bus_write && $past(bus_sel && !bus_enable))
      |-> bus_rdata == '0);

  // R6: a read of a hole returns zero
  p_hole_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_enable && !bus_write && hole) |-> bus_rdata == '0);

  // R8: an enable cycle without a preceding setup drives nothing
  p_no_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_enable && !$past(bus_sel && !bus_enable)) |-> bus_rdata == '0);
endmodule

bind apbm_mem_slave apbm_mem_slave_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_enable (bus_enable),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata)
);

// File: tb/apbm_mem_slave_test.sv
`timescale 1ns/1ps
module apbm_mem_slave_test;
  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_enable;
  logic        bus_write;
  logic [31:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  apbm_mem_slave uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_enable (bus_enable),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {is_write, address, write data or expected read data}
  localparam int NV = 15;
  localparam logic [64:0] VEC [NV] = '{
    {1'b1, 32'h0000_0000, 32'h1111_0000},
    {1'b1, 32'h0000_0004, 32'hA5A5_A5A5},
    {1'b1, 32'h0000_0FFC, 32'hDEAD_BEEF},  // last word (R10)
    {1'b0, 32'h0000_0000, 32'h1111_0000},
    {1'b0, 32'h0000_0004, 32'hA5A5_A5A5},
    {1'b0, 32'h0000_0FFC, 32'hDEAD_BEEF},
    {1'b0, 32'h0000_0008, 32'h0000_0000},  // never written (R4)
    {1'b1, 32'h0000_0004, 32'h0BAD_F00D},
    {1'b0, 32'h0000_0004, 32'h0BAD_F00D},
    {1'b1, 32'h0000_1000, 32'hFFFF_FFFF},  // hole aliasing word 0 (R6)
    {1'b0, 32'h0000_0000, 32'h1111_0000},
    {1'b0, 32'h0000_1000, 32'h0000_0000},
    {1'b0, 32'h0000_0002, 32'h0000_0000},  // misaligned read
    {1'b1, 32'h0000_0001, 32'h1234_5678},  // misaligned write
    {1'b0, 32'h0000_0000, 32'h1111_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_enable = 1'b0; bus_write = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_enable = 1'b0; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_enable = 1'b1;
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] got);
    @(negedge clk);
    bus_sel = 1'b1; bus_enable = 1'b0; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_enable = 1'b1;
    #1 got = bus_rdata;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    bus_sel = 1'b0; bus_enable = 1'b0;
    rst_n = 1'b0;
    #1 chk("R1 reset clears read bus", bus_rdata, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    rst_n = 1'b1; bus_sel = 1'b0; bus_enable = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    #2 rst_n = 1'b0;
    @(negedge clk);
    #1 chk("R1 read bus during reset", bus_rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4: fresh memory reads zero
    do_read(32'h0000_0010, got);
    chk("R4 unwritten word", got, 32'h0);

    // table walk: R3 for reads, with R4/R6/R10 cases inside
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][64]) begin
        do_write(VEC[i][63:32], VEC[i][31:0]);
      end else begin
        do_read(VEC[i][63:32], got);
        chk("R3 table read", got, VEC[i][31:0]);
      end
    end
    go_idle();

    // R10 explicit
    do_read(32'h0000_0FFC, got);
    chk("R10 last word", got, 32'hDEAD_BEEF);
    // R7: bus returns to zero after the read access ends
    go_idle();
    #1 chk("R7 zero after read", bus_rdata, 32'h0);

    // R2 and R7: write access cycle keeps read bus at zero
    do_write(32'h0000_0020, 32'hCAFE_0001);
    #1 chk("R7 zero in write access", bus_rdata, 32'h0);
    do_read(32'h0000_0020, got);
    chk("R2 committed word", got, 32'hCAFE_0001);

    // R9: back-to-back write then read, same address
    do_write(32'h0000_0030, 32'h5555_AAAA);
    do_read(32'h0000_0030, got);
    chk("R9 read right after write", got, 32'h5555_AAAA);
    go_idle();

    // R8: enable cycle without setup writes nothing
    @(negedge clk);
    bus_sel = 1'b1; bus_enable = 1'b1; bus_write = 1'b1;
    bus_addr = 32'h0000_0040; bus_wdata = 32'h7777_7777;
    go_idle();
    do_read(32'h0000_0040, got);
    chk("R8 write without setup ignored", got, 32'h0);
    go_idle();
    // R8: read-style enable cycle without setup drives nothing
    @(negedge clk);
    bus_sel = 1'b1; bus_enable = 1'b1; bus_write = 1'b0; bus_addr = 32'h0000_0020;
    @(negedge clk);
    #1 chk("R8 read without setup silent", bus_rdata, 32'h0);
    go_idle();

    // R1: reset during a read access clears the bus without an edge
    @(negedge clk);
    bus_sel = 1'b1; bus_enable = 1'b0; bus_write = 1'b0; bus_addr = 32'h0000_0020;
    @(negedge clk);
    bus_enable = 1'b1;
    #1 chk("R3 read before reset", bus_rdata, 32'hCAFE_0001);
    #1 rst_n = 1'b0;
    #1 chk("R1 async clear mid-read", bus_rdata, 32'h0);
    @(negedge clk);
    bus_sel = 1'b0; bus_enable = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5: every word invalid after reset
    do_read(32'h0000_0020, got);
    chk("R5 cleared by reset", got, 32'h0);
    do_read(32'h0000_0FFC, got);
    chk("R5 last word cleared", got, 32'h0);
    do_read(32'h0000_0000, got);
    chk("R5 word 0 cleared", got, 32'h0);

    // R5 via task reset, then rewrite works again
    do_write(32'h0000_0100, 32'h0F0F_0F0F);
    apply_reset();
    do_read(32'h0000_0100, got);
    chk("R5 reset after write", got, 32'h0);
    do_write(32'h0000_0100, 32'h3C3C_3C3C);
    do_read(32'h0000_0100, got);
    chk("R2 write after reset", got, 32'h3C3C_3C3C);
    go_idle();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule